// File: doc/BRIEF.md
# Steerable Interrupt Aggregator

This block collects thirty-two interrupt request lines into one status word. Each line is synchronised to the local clock and then qualified by its own polarity and detection mode. In level mode the status bit mirrors the qualified line. In edge mode the status bit latches a transition and holds it until software clears it. An enable mask turns status into a masked view. A per-line steering mask then sends every masked request to one of two processor-facing outputs: an urgent one and an ordinary one.

Software reaches the block over a plain word-wide register bus with an address, a write strobe, a read strobe and data in each direction. Dispatch code can skip scanning the masked word: the block also drives the number of the lowest-numbered pending source and a flag that says whether any source is pending. Instances can be chained: the ordinary or urgent output of one instance drives one request line of another. The upstream handler then reads the downstream masked view.

Top module: `intc_steer`

## Requirements
- R1: Source n (0..31) occupies bit 31-n of `irq_in` and of every register, so source 0 is the most significant bit. `pend_idx` reports the source number n, not the bit position.
- R2: After reset, the status, enable, urgent-select and mode registers read zero and the polarity register reads all ones. `irq_crit`, `irq_noncrit` and `pend_valid` are low.
- R3: Register offsets on `bus_addr` are: 0 status, 1 enable, 2 urgent select, 3 polarity, 4 mode, 5 masked status. A read strobe returns the addressed word on `bus_rdata` one cycle later. Offsets 6 and 7 read zero, and writes to them or to offset 5 change nothing.
- R4: With mode bit 0 (level), a status bit equals the qualified line three cycles after the line changes. Writing a one to it has no effect while the line stays active.
- R5: With mode bit 1 (edge), an inactive-to-active transition of the qualified line sets the status bit. The bit stays set after the line returns to idle until a one is written to it at offset 0. Writing zero leaves it set.
- R6: A polarity bit of 1 makes a high level or a rising edge active. A polarity bit of 0 makes a low level or a falling edge active.
- R7: The masked status (offset 5) reads as status AND enable.
- R8: `irq_crit` is the OR of masked bits whose urgent-select bit is 1. `irq_noncrit` is the OR of masked bits whose urgent-select bit is 0.
- R9: `pend_idx` is the lowest source number with a masked bit set, and `pend_valid` is high exactly when the masked status is nonzero.
- R10: In edge mode, when a new edge arrives in the same cycle as a clearing write for that bit, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 32 | Request lines, source n on bit 31-n |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| irq_crit | output | 1 | Urgent interrupt request |
| irq_noncrit | output | 1 | Ordinary interrupt request |
| pend_idx | output | 5 | Lowest pending source number |
| pend_valid | output | 1 | Some masked source is pending |

## Verification
The assertions assume that the request lines reach the synchroniser cleanly, so a qualified line is either stable or making one transition per cycle. They also assume that the enable, urgent and mode masks change only through the bus. The bench changes `irq_in` and the bus strobes only at falling clock edges. It leaves a settle window of several cycles after each change of a request line before it reads status, except in the one test that times an edge against a clearing write to the exact cycle.

// File: rtl/intc_pkg.sv
package intc_pkg;

   localparam int unsigned REG_AW = 3;

   typedef enum logic [REG_AW-1:0] {
      OFS_STAT = 3'd0,
      OFS_EN   = 3'd1,
      OFS_CRIT = 3'd2,
      OFS_POL  = 3'd3,
      OFS_TRIG = 3'd4,
      OFS_MASK = 3'd5
   } reg_ofs_e;

endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
   parameter int unsigned W      = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_in,
   output logic [W-1:0] d_out
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign d_out = d_in;
      end else begin : g_chain
         logic [W-1:0] stage_q [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int s = 0; s < int'(STAGES); s++) stage_q[s] <= '0;
            end else begin
               stage_q[0] <= d_in;
               for (int s = 1; s < int'(STAGES); s++) stage_q[s] <= stage_q[s-1];
            end
         end
         assign d_out = stage_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/intc_detect.sv
module intc_detect #(
   parameter int unsigned W                = 32,
   parameter bit          EDGE_BEATS_CLEAR = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] line_s,
   input  logic [W-1:0] pol,
   input  logic [W-1:0] trig,
   input  logic [W-1:0] clr,
   output logic [W-1:0] qual,
   output logic [W-1:0] stat
);

   logic [W-1:0] prev_q;
   logic [W-1:0] stat_q;
   logic [W-1:0] stat_d;

   assign qual = ~(line_s ^ pol);

   generate
      for (genvar i = 0; i < int'(W); i++) begin : g_src
         logic rise_i;
         assign rise_i = qual[i] & ~prev_q[i];
         if (EDGE_BEATS_CLEAR) begin : g_set_wins
            assign stat_d[i] = trig[i] ? ((stat_q[i] & ~clr[i]) | rise_i) : qual[i];
         end else begin : g_clr_wins
            assign stat_d[i] = trig[i] ? ((stat_q[i] | rise_i) & ~clr[i]) : qual[i];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         stat_q <= '0;
      end else begin
         prev_q <= qual;
         stat_q <= stat_d;
      end
   end

   assign stat = stat_q;

endmodule

// File: rtl/intc_regs.sv
module intc_regs
   import intc_pkg::*;
#(
   parameter int unsigned    W         = 32,
   parameter logic [W-1:0]   POL_RESET = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [REG_AW-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [W-1:0]      bus_wdata,
   input  logic [W-1:0]      stat,
   output logic [W-1:0]      en,
   output logic [W-1:0]      crit,
   output logic [W-1:0]      pol,
   output logic [W-1:0]      trig,
   output logic [W-1:0]      clr,
   output logic [W-1:0]      rdata
);

   logic [W-1:0] en_q, crit_q, pol_q, trig_q, rdata_q, rmux;
   reg_ofs_e     ofs;

   assign ofs = reg_ofs_e'(bus_addr);
   assign clr = (bus_wr && ofs == OFS_STAT) ? bus_wdata : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= '0;
         crit_q <= '0;
         pol_q  <= POL_RESET;
         trig_q <= '0;
      end else if (bus_wr) begin
         case (ofs)
            OFS_EN:   en_q   <= bus_wdata;
            OFS_CRIT: crit_q <= bus_wdata;
            OFS_POL:  pol_q  <= bus_wdata;
            OFS_TRIG: trig_q <= bus_wdata;
            default:  ;
         endcase
      end
   end

   always_comb begin
      case (ofs)
         OFS_STAT: rmux = stat;
         OFS_EN:   rmux = en_q;
         OFS_CRIT: rmux = crit_q;
         OFS_POL:  rmux = pol_q;
         OFS_TRIG: rmux = trig_q;
         OFS_MASK: rmux = stat & en_q;
         default:  rmux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rdata_q <= '0;
      else if (bus_rd) rdata_q <= rmux;
   end

   assign en    = en_q;
   assign crit  = crit_q;
   assign pol   = pol_q;
   assign trig  = trig_q;
   assign rdata = rdata_q;

endmodule

// File: rtl/intc_prio.sv
module intc_prio #(
   parameter int unsigned W  = 32,
   localparam int unsigned IW = $clog2(W)
) (
   input  logic [W-1:0]  masked,
   input  logic [W-1:0]  crit,
   output logic [IW-1:0] idx,
   output logic          valid,
   output logic          out_crit,
   output logic          out_noncrit
);

   always_comb begin
      idx = '0;
      for (int i = 0; i < int'(W); i++) begin
         if (masked[i]) idx = IW'(int'(W) - 1 - i);
      end
   end

   assign valid       = |masked;
   assign out_crit    = |(masked & crit);
   assign out_noncrit = |(masked & ~crit);

endmodule

// File: rtl/intc_steer.sv
module intc_steer
   import intc_pkg::*;
#(
   parameter int unsigned  N_SRC            = 32,
   parameter int unsigned  SYNC_STAGES      = 2,
   parameter logic [31:0]  POL_RESET        = 32'hFFFF_FFFF,
   parameter bit           EDGE_BEATS_CLEAR = 1'b1,
   localparam int unsigned IDX_W            = $clog2(N_SRC)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SRC-1:0]  irq_in,
   input  logic [REG_AW-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [N_SRC-1:0]  bus_wdata,
   output logic [N_SRC-1:0]  bus_rdata,
   output logic              irq_crit,
   output logic              irq_noncrit,
   output logic [IDX_W-1:0]  pend_idx,
   output logic              pend_valid
);

   generate
      if (N_SRC != 32) begin : g_bad_width
         $error("intc_steer: N_SRC must equal the 32-bit register width");
      end
      if (SYNC_STAGES > 4) begin : g_bad_sync
         $error("intc_steer: SYNC_STAGES above 4 is not supported");
      end
   endgenerate

   logic [N_SRC-1:0] line_s;
   logic [N_SRC-1:0] qual;
   logic [N_SRC-1:0] stat_q;
   logic [N_SRC-1:0] en_q, crit_q, pol_q, trig_q, clr_vec;

   intc_sync #(.W(N_SRC), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (irq_in),
      .d_out (line_s)
   );

   intc_detect #(.W(N_SRC), .EDGE_BEATS_CLEAR(EDGE_BEATS_CLEAR)) u_detect (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_s (line_s),
      .pol    (pol_q),
      .trig   (trig_q),
      .clr    (clr_vec),
      .qual   (qual),
      .stat   (stat_q)
   );

   intc_regs #(.W(N_SRC), .POL_RESET(POL_RESET[N_SRC-1:0])) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_wdata (bus_wdata),
      .stat      (stat_q),
      .en        (en_q),
      .crit      (crit_q),
      .pol       (pol_q),
      .trig      (trig_q),
      .clr       (clr_vec),
      .rdata     (bus_rdata)
   );

   intc_prio #(.W(N_SRC)) u_prio (
      .masked      (stat_q & en_q),
      .crit        (crit_q),
      .idx         (pend_idx),
      .valid       (pend_valid),
      .out_crit    (irq_crit),
      .out_noncrit (irq_noncrit)
   );

endmodule

// File: rtl/intc_steer_chk.sv
module intc_steer_chk #(
   parameter int unsigned  N_SRC = 32,
   localparam int unsigned IDX_W = $clog2(N_SRC)
) (
   input logic             clk,
   input logic             rst_n,
   input logic [N_SRC-1:0] stat_q,
   input logic [N_SRC-1:0] en_q,
   input logic [N_SRC-1:0] crit_q,
   input logic [N_SRC-1:0] trig_q,
   input logic [N_SRC-1:0] qual,
   input logic [N_SRC-1:0] clr_vec,
   input logic             irq_crit,
   input logic             irq_noncrit,
   input logic [IDX_W-1:0] pend_idx,
   input logic             pend_valid
);

   logic [N_SRC-1:0] masked;
   assign masked = stat_q & en_q;

   p_reset_masks_r2: assert property (@(posedge clk)
      !rst_n |=> (en_q == '0 && crit_q == '0 && trig_q == '0 && stat_q == '0));

   p_level_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat_q ^ $past(qual)) & ~trig_q & ~$past(trig_q)) == '0);

   p_edge_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(stat_q) & ~stat_q & trig_q & $past(trig_q) & ~$past(clr_vec)) == '0);

   p_outputs_cover_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_crit || irq_noncrit) == pend_valid);

   p_index_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
      pend_valid |-> masked[N_SRC - 1 - int'(pend_idx)]);

   p_index_lowest_r9: assert property (@(posedge clk) disable iff (!rst_n)
      pend_valid |-> ((masked >> (N_SRC - int'(pend_idx))) == '0));

endmodule

bind intc_steer intc_steer_chk #(.N_SRC(N_SRC)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .stat_q      (stat_q),
   .en_q        (en_q),
   .crit_q      (crit_q),
   .trig_q      (trig_q),
   .qual        (qual),
   .clr_vec     (clr_vec),
   .irq_crit    (irq_crit),
   .irq_noncrit (irq_noncrit),
   .pend_idx    (pend_idx),
   .pend_valid  (pend_valid)
);

// File: tb/intc_steer_bench.sv
`timescale 1ns/1ps
module intc_steer_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] irq_in = '0;
   logic [2:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_crit, irq_noncrit, pend_valid;
   logic [4:0]  pend_idx;

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   intc_steer u_intc_steer (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
      .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_crit(irq_crit), .irq_noncrit(irq_noncrit),
      .pend_idx(pend_idx), .pend_valid(pend_valid)
   );

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      vectors++;
      if (got !== exp) begin
         miscompares++;
         $display("FAIL %s got %h expected %h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic settle();
      repeat (5) @(negedge clk);
   endtask

   function automatic int lowest_src(input logic [31:0] v);
      for (int b = 31; b >= 0; b--) if (v[b]) return 31 - b;
      return 0;
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog expired");
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      logic [31:0] d, m, en, pat, msk;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 reset state
      rd(3'd0, d); chk("R2 status", d, 32'h0);
      rd(3'd1, d); chk("R2 enable", d, 32'h0);
      rd(3'd2, d); chk("R2 urgent", d, 32'h0);
      rd(3'd3, d); chk("R2 polarity", d, 32'hFFFF_FFFF);
      rd(3'd4, d); chk("R2 mode", d, 32'h0);
      chk("R2 outputs", {29'h0, irq_crit, irq_noncrit, pend_valid}, 32'h0);

      // R3 register access, offsets and ignored writes
      wr(3'd1, 32'h1234_5678); rd(3'd1, d); chk("R3 enable rw", d, 32'h1234_5678);
      wr(3'd2, 32'h0F0F_0F0F); rd(3'd2, d); chk("R3 urgent rw", d, 32'h0F0F_0F0F);
      wr(3'd3, 32'hA5A5_A5A5); rd(3'd3, d); chk("R3 polarity rw", d, 32'hA5A5_A5A5);
      wr(3'd4, 32'h5A5A_5A5A); rd(3'd4, d); chk("R3 mode rw", d, 32'h5A5A_5A5A);
      wr(3'd5, 32'hFFFF_FFFF); wr(3'd6, 32'hFFFF_FFFF); wr(3'd7, 32'hFFFF_FFFF);
      rd(3'd1, d); chk("R3 enable after stray writes", d, 32'h1234_5678);
      rd(3'd4, d); chk("R3 mode after stray writes", d, 32'h5A5A_5A5A);
      rd(3'd6, d); chk("R3 offset 6 reads zero", d, 32'h0);
      rd(3'd7, d); chk("R3 offset 7 reads zero", d, 32'h0);
      wr(3'd2, 32'h0); wr(3'd3, 32'hFFFF_FFFF); wr(3'd4, 32'h0);
      wr(3'd0, 32'hFFFF_FFFF); wr(3'd1, 32'hFFFF_FFFF);
      settle();

      // R1 R4 R8 R9 level-high sweep over every source
      for (int n = 0; n < 32; n++) begin
         m = 32'h1 << (31 - n);
         irq_in = m; settle();
         rd(3'd0, d); chk("R1 R4 level status bit", d, m);
         chk("R9 index", {27'h0, pend_idx}, 32'(n));
         chk("R8 ordinary out", {30'h0, irq_crit, irq_noncrit}, 32'h1);
         wr(3'd0, 32'hFFFF_FFFF); @(negedge clk);
         rd(3'd0, d); chk("R4 clear ignored while active", d, m);
         irq_in = '0; settle();
         rd(3'd0, d); chk("R4 level drops", d, 32'h0);
      end

      // R8 urgent steering
      for (int n = 0; n < 32; n += 3) begin
         m = 32'h1 << (31 - n);
         wr(3'd2, m); irq_in = m; settle();
         chk("R8 urgent out", {30'h0, irq_crit, irq_noncrit}, 32'h2);
         irq_in = m | (32'h1 << (n % 31)) | 32'h1; settle();
         chk("R8 both outs", {30'h0, irq_crit, irq_noncrit},
             ((m | (32'h1 << (n % 31)) | 32'h1) & ~m) != 0 ? 32'h3 : 32'h2);
         irq_in = '0; settle();
      end
      wr(3'd2, 32'h0);

      // R6 active-low level
      for (int n = 0; n < 32; n += 5) begin
         m = 32'h1 << (31 - n);
         wr(3'd3, ~m); settle();
         rd(3'd0, d); chk("R6 low level active", d, m);
         irq_in = m; settle();
         rd(3'd0, d); chk("R6 high level idle", d, 32'h0);
         wr(3'd3, 32'hFFFF_FFFF); irq_in = '0; settle();
      end

      // R5 rising-edge latch sweep
      wr(3'd4, 32'hFFFF_FFFF); settle();
      for (int n = 0; n < 32; n++) begin
         m = 32'h1 << (31 - n);
         irq_in = m; settle(); irq_in = '0; settle();
         rd(3'd0, d); chk("R5 edge held after idle", d, m);
         wr(3'd0, ~m);
         rd(3'd0, d); chk("R5 zero write keeps bit", d, m);
         wr(3'd0, m);
         rd(3'd0, d); chk("R5 one write clears", d, 32'h0);
      end

      // R6 falling edge
      for (int n = 2; n < 32; n += 7) begin
         m = 32'h1 << (31 - n);
         irq_in = m; settle();
         wr(3'd3, ~m); wr(3'd0, 32'hFFFF_FFFF); settle();
         rd(3'd0, d); chk("R6 falling setup clear", d, 32'h0);
         irq_in = '0; settle();
         rd(3'd0, d); chk("R6 falling edge latched", d, m);
         wr(3'd3, 32'hFFFF_FFFF); wr(3'd0, 32'hFFFF_FFFF); settle();
         rd(3'd0, d); chk("R6 falling cleanup", d, 32'h0);
      end

      // R10 edge in the same cycle as clear
      m = 32'h1 << (31 - 5);
      irq_in = m; settle(); irq_in = '0; settle();
      irq_in = m;
      @(negedge clk); @(negedge clk);
      wr(3'd0, m);
      settle();
      rd(3'd0, d); chk("R10 edge beats clear", d, m);
      irq_in = '0; settle(); wr(3'd0, 32'hFFFF_FFFF);
      wr(3'd4, 32'h0); settle();

      // R7 R9 masked view and priority over mixed patterns
      for (int k = 0; k < 12; k++) begin
         pat = (32'hDEAD_BEEF << k) ^ (32'(k) * 32'h0101_0101);
         en  = (32'h0F0F_3C3C >> k) | (32'h1 << k);
         wr(3'd1, en); irq_in = pat; settle();
         msk = pat & en;
         rd(3'd5, d); chk("R7 masked status", d, msk);
         chk("R9 valid", {31'h0, pend_valid}, {31'h0, msk != 0});
         if (msk != 0) chk("R9 lowest index", {27'h0, pend_idx}, 32'(lowest_src(msk)));
      end
      wr(3'd1, 32'h0); settle();
      chk("R9 nothing enabled", {29'h0, pend_valid, irq_crit, irq_noncrit}, 32'h0);
      rd(3'd5, d); chk("R7 masked with enable off", d, 32'h0);
      irq_in = '0; settle();

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule